// File: doc/BRIEF.md
# Sensor Fault Diagnostic Manager

This block gathers four supply and temperature fault conditions from a sensor front end. Each condition is qualified, latched as a sticky flag, and turned into a forced-output request for the PWM or SENT output stage downstream. The four conditions are supply undervoltage, supply overvoltage, overtemperature and undertemperature. Supply faults must persist for a deglitch window of microsecond ticks before they count. Temperature conditions are sampled once every few millisecond ticks and take effect on a single sample. Once a fault has forced the output, the forced state stays for a minimum hold time. That hold time is longer when the PWM carrier is slow, so that at least two carrier periods show the fault.

Flags are kept in four copies. One copy serves the register read and PWM reporting path. Each of the three SENT reporting paths has its own copy, and each copy is cleared by its own transmit strobe. A flag clears only after its condition has gone. Power-on reset floats the output, and on its release the undervoltage flag is raised if that diagnostic is enabled. An overvoltage seen while overvoltage diagnostics are off, the output is digital and the programming-trigger setting is 0 or 1 moves the block into a sticky communication mode with the output floating.

Top module: `fault_diag_mgr`

## Requirements
- R1: After synchronous reset every flag, `out_code`, `out_force`, `out_hiz` and `comm_mode` read 0.
- R2: A supply fault input (`uv_raw`, `ov_raw`) becomes qualified on the DEGLITCH_US-th consecutive `tick_us` pulse seen while it is high. A low level discards the count, so a shorter high pulse never sets a flag.
- R3: `ot_raw` and `ut_raw` are sampled on every TEMP_PERIOD_MS-th `tick_ms` pulse after reset, and a single high sample qualifies the condition.
- R4: A flag is set while its condition is qualified and enabled. It stays set until a clear arrives while the condition is absent. A clear that coincides with a present condition loses.
- R5: The main flags (`reg_flags`) clear on `reg_read` or `pwm_report`. Flag bit positions are UV=0, OV=1, OT=2, UT=3.
- R6: With `pwm_slow`=0, `out_force` stays high for HOLD_MS `tick_ms` pulses after the last cycle an enabled fault was qualified. A fault that returns during the hold restarts the count.
- R7: With `pwm_slow`=1 the minimum hold is HOLD_SLOW_MS `tick_ms` pulses.
- R8: `out_code` reports only the highest-priority set main flag, with code = bit position + 1 (UV=1 highest, UT=4 lowest). It keeps the last code while only the hold keeps the output forced, and reads 0 otherwise.
- R9: A diagnostic whose `diag_en` bit is 0 sets no flag and never raises `out_force`.
- R10: While `por_active` is high, `out_hiz`=1 and `out_force`=0. On its falling edge the UV flag is set in every copy if `diag_en[0]`=1.
- R11: A qualified overvoltage sets `comm_mode`=1 and `out_hiz`=1 if all of these hold: `diag_en[1]`=0, `digital_mode`=1 and `mtrig_cfg` is 0 or 1. `comm_mode` then holds until reset. Otherwise no mode change occurs.
- R12: `sent_flags[4p+3:4p]` is the copy for SENT path p (p=0..2). It is cleared only by `sent_tx[p]`, and each copy clears independently of the others and of the main copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| por_active | input | 1 | Power-on reset comparator active |
| uv_raw | input | 1 | Undervoltage comparator output |
| ov_raw | input | 1 | Overvoltage comparator output |
| ot_raw | input | 1 | Temperature above upper limit |
| ut_raw | input | 1 | Temperature below lower limit |
| diag_en | input | 4 | Per-diagnostic enable (UV, OV, OT, UT at bits 0..3) |
| pwm_slow | input | 1 | PWM carrier at or below 500 Hz |
| digital_mode | input | 1 | Output stage in a digital protocol |
| mtrig_cfg | input | 2 | Programming-entry trigger setting |
| reg_read | input | 1 | Register read strobe clearing main flags |
| pwm_report | input | 1 | PWM frame reported the fault, clears main flags |
| sent_tx | input | 3 | Per-SENT-path flag transmitted strobe |
| reg_flags | output | 4 | Main flag copy |
| sent_flags | output | 12 | Three SENT flag copies, 4 bits each |
| out_code | output | 3 | Reported fault code, 0 = none |
| out_force | output | 1 | Request to force the output to its fault state |
| out_hiz | output | 1 | Request to float the output |
| comm_mode | output | 1 | Communication mode entered |

## Verification
The bench builds the block with its default parameters: a 20-tick supply deglitch, holds of 5 and 16 ms ticks and an 8-tick temperature interval. Because both timebases are inputs, the bench steps them one pulse at a time. It can therefore land exactly on the 19th and 20th deglitch tick, the 7th and 8th temperature tick, and the last cycle of each hold window. These full-size values fit within the run, so the boundary at each real limit is reached rather than a scaled stand-in.

// File: rtl/fdm_pkg.sv
// Shared constants and helpers for the fault diagnostic manager.
package fdm_pkg;
    localparam int NF    = 4;   // number of fault kinds
    localparam int NSENT = 3;   // SENT reporting paths
    localparam int NPATH = NSENT + 1; // plus the main copy
    localparam int CW    = 3;   // width of a fault code

    // flag bit positions; lower position = higher priority
    localparam int F_UV = 0;
    localparam int F_OV = 1;
    localparam int F_OT = 2;
    localparam int F_UT = 3;

    // Highest-priority set flag as position + 1, or 0 when none is set.
    function automatic logic [CW-1:0] prio_code(input logic [NF-1:0] f);
        logic [CW-1:0] c;
        c = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (f[i]) c = CW'(i + 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/fdm_deglitch.sv
// Entry deglitch for one supply fault comparator.
// Assumes tick is a one-cycle pulse; the qualified output rises on the
// LIMIT-th consecutive tick seen with raw high and drops as soon as raw is low.
module fdm_deglitch #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic qual
);
    localparam int CNTW = $clog2(LIMIT + 1);

    logic [CNTW-1:0] cnt;

    // count consecutive ticks with raw high, release at once on raw low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (!raw) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (tick && !qual) begin
            if (cnt == CNTW'(LIMIT - 1)) qual <= 1'b1;
            else                         cnt  <= cnt + 1'b1;
        end
    end

    p_low_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !qual);
    p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && !tick) |=> !qual);
endmodule

// File: rtl/fdm_temp_sampler.sv
// Periodic sampler for the temperature limit conditions.
// Assumes tick_ms is a one-cycle pulse; both conditions are captured on every
// PERIOD-th tick after reset, with no filtering beyond the single sample.
module fdm_temp_sampler #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic ot_raw,
    input  logic ut_raw,
    output logic ot_q,
    output logic ut_q
);
    localparam int PW = $clog2(PERIOD + 1);

    logic [PW-1:0] phase;

    // step the sampling phase and capture on its last tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            ot_q  <= 1'b0;
            ut_q  <= 1'b0;
        end else if (tick_ms) begin
            if (phase == PW'(PERIOD - 1)) begin
                phase <= '0;
                ot_q  <= ot_raw;
                ut_q  <= ut_raw;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> ($stable(ot_q) && $stable(ut_q)));
endmodule

// File: rtl/fdm_flag_bank.sv
// One sticky copy of the fault flags.
// Assumes set is already gated by the enables; a clear only removes a flag
// whose condition is absent, and a set in the same cycle always wins.
module fdm_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] cond,
    input  logic         clr,
    output logic [N-1:0] flags
);
    // per-bit set-dominant sticky latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (set[i])                 flags[i] <= 1'b1;
                else if (clr && !cond[i])   flags[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags[g]);
        p_held_while_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && cond[g]) |=> flags[g]);
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !clr) |=> flags[g]);
    end
endmodule

// File: rtl/fdm_hold_timer.sv
// Minimum hold counter for the forced fault state.
// Reloads while any enabled fault is active and counts down one per tick_ms
// afterwards; the limit is picked by the slow-carrier selection.
module fdm_hold_timer #(
    parameter int HOLD_FAST = 5,
    parameter int HOLD_SLOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic fault_act,
    input  logic slow,
    output logic holding
);
    localparam int HMAX = (HOLD_SLOW > HOLD_FAST) ? HOLD_SLOW : HOLD_FAST;
    localparam int HW   = $clog2(HMAX + 1);

    logic [HW-1:0] cnt;

    // reload on activity, otherwise count down on millisecond ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fault_act) begin
            cnt <= slow ? HW'(HOLD_SLOW) : HW'(HOLD_FAST);
        end else if (tick_ms && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign holding = (cnt != '0);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_act |=> holding);
    p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!holding && !fault_act) |=> !holding);
    p_no_tick_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_act && !tick_ms) |=> $stable(cnt));
endmodule

// File: rtl/fault_diag_mgr.sv
// Sensor fault diagnostic manager (top).
// Qualifies supply and temperature faults, keeps a main flag copy and one copy
// per SENT path, picks the highest-priority fault and drives force and float
// requests to the output stage. Assumes tick_us/tick_ms are one-cycle pulses.
module fault_diag_mgr
    import fdm_pkg::*;
#(
    parameter int DEGLITCH_US    = 20,
    parameter int HOLD_MS        = 5,
    parameter int HOLD_SLOW_MS   = 16,
    parameter int TEMP_PERIOD_MS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_us,
    input  logic                tick_ms,
    input  logic                por_active,
    input  logic                uv_raw,
    input  logic                ov_raw,
    input  logic                ot_raw,
    input  logic                ut_raw,
    input  logic [NF-1:0]       diag_en,
    input  logic                pwm_slow,
    input  logic                digital_mode,
    input  logic [1:0]          mtrig_cfg,
    input  logic                reg_read,
    input  logic                pwm_report,
    input  logic [NSENT-1:0]    sent_tx,
    output logic [NF-1:0]       reg_flags,
    output logic [NSENT*NF-1:0] sent_flags,
    output logic [CW-1:0]       out_code,
    output logic                out_force,
    output logic                out_hiz,
    output logic                comm_mode
);
    logic          uv_q, ov_q, ot_q, ut_q;
    logic [NF-1:0] cond, set_v;
    logic          por_d, por_fall;
    logic          holding;
    logic [CW-1:0] code_q;
    logic [NF-1:0]    path_flags [NPATH];
    logic [NPATH-1:0] path_clr;

    fdm_deglitch #(.LIMIT(DEGLITCH_US)) u_uv (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .raw(uv_raw), .qual(uv_q));
    fdm_deglitch #(.LIMIT(DEGLITCH_US)) u_ov (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .raw(ov_raw), .qual(ov_q));

    fdm_temp_sampler #(.PERIOD(TEMP_PERIOD_MS)) u_temp (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .ot_raw(ot_raw), .ut_raw(ut_raw), .ot_q(ot_q), .ut_q(ut_q));

    // remember the reset comparator to find its release
    always_ff @(posedge clk) begin
        if (!rst_n) por_d <= 1'b0;
        else        por_d <= por_active;
    end
    assign por_fall = por_d && !por_active;

    // qualified conditions and enabled set requests
    always_comb begin
        cond        = '0;
        cond[F_UV]  = uv_q;
        cond[F_OV]  = ov_q;
        cond[F_OT]  = ot_q;
        cond[F_UT]  = ut_q;
        set_v       = cond & diag_en;
        if (por_fall && diag_en[F_UV]) set_v[F_UV] = 1'b1;
    end

    // clear strobes: main copy from read or PWM report, others per SENT path
    always_comb begin
        path_clr[0] = reg_read || pwm_report;
        for (int p = 0; p < NSENT; p++) path_clr[p+1] = sent_tx[p];
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        fdm_flag_bank #(.N(NF)) u_bank (
            .clk(clk), .rst_n(rst_n), .set(set_v), .cond(cond),
            .clr(path_clr[p]), .flags(path_flags[p]));
    end

    assign reg_flags = path_flags[0];
    for (genvar p = 0; p < NSENT; p++) begin : g_sent_out
        assign sent_flags[p*NF +: NF] = path_flags[p+1];
    end

    fdm_hold_timer #(.HOLD_FAST(HOLD_MS), .HOLD_SLOW(HOLD_SLOW_MS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .fault_act(|set_v),
        .slow(pwm_slow), .holding(holding));

    // keep the last reported code for the hold-only interval
    always_ff @(posedge clk) begin
        if (!rst_n)          code_q <= '0;
        else if (|reg_flags) code_q <= prio_code(reg_flags);
    end

    // sticky entry into communication mode on an undiagnosed overvoltage
    always_ff @(posedge clk) begin
        if (!rst_n)
            comm_mode <= 1'b0;
        else if (ov_q && !diag_en[F_OV] && digital_mode && !mtrig_cfg[1])
            comm_mode <= 1'b1;
    end

    assign out_hiz   = por_active || comm_mode;
    assign out_force = !out_hiz && ((|reg_flags) || holding);
    assign out_code  = (|reg_flags) ? prio_code(reg_flags)
                     : (holding ? code_q : '0);

    p_hiz_blocks_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz |-> !out_force);
    p_comm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        comm_mode |=> comm_mode);
    p_code_needs_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_hiz && !out_force) |-> (out_code == '0));
endmodule

// File: tb/tb_fault_diag_mgr.sv
// Directed bench for the fault diagnostic manager.
module tb_fault_diag_mgr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 0, tick_ms = 0, por_active = 0;
    logic uv_raw = 0, ov_raw = 0, ot_raw = 0, ut_raw = 0;
    logic [3:0] diag_en = 4'hF;
    logic pwm_slow = 0, digital_mode = 0;
    logic [1:0] mtrig_cfg = 2'b00;
    logic reg_read = 0, pwm_report = 0;
    logic [2:0] sent_tx = '0;
    logic [3:0] reg_flags;
    logic [11:0] sent_flags;
    logic [2:0] out_code;
    logic out_force, out_hiz, comm_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fault_diag_mgr dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tick_ms(tick_ms),
        .por_active(por_active), .uv_raw(uv_raw), .ov_raw(ov_raw),
        .ot_raw(ot_raw), .ut_raw(ut_raw), .diag_en(diag_en),
        .pwm_slow(pwm_slow), .digital_mode(digital_mode), .mtrig_cfg(mtrig_cfg),
        .reg_read(reg_read), .pwm_report(pwm_report), .sent_tx(sent_tx),
        .reg_flags(reg_flags), .sent_flags(sent_flags), .out_code(out_code),
        .out_force(out_force), .out_hiz(out_hiz), .comm_mode(comm_mode));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tick_us = 0; tick_ms = 0; por_active = 0;
        uv_raw = 0; ov_raw = 0; ot_raw = 0; ut_raw = 0;
        diag_en = 4'hF; pwm_slow = 0; digital_mode = 0; mtrig_cfg = 2'b00;
        reg_read = 0; pwm_report = 0; sent_tx = '0;
        idle(3);
        rst_n = 1;
        idle(1);
    endtask

    task automatic us_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_us = 1; @(negedge clk); tick_us = 0; @(negedge clk);
        end
    endtask

    task automatic ms_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1; @(negedge clk); tick_ms = 0; @(negedge clk);
        end
    endtask

    task automatic pulse_read();
        reg_read = 1; @(negedge clk); reg_read = 0; idle(2);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reg_flags", reg_flags, 0);
        check("R1 sent_flags", sent_flags, 0);
        check("R1 out_code", out_code, 0);
        check("R1 out_force", out_force, 0);
        check("R1 out_hiz", out_hiz, 0);
        check("R1 comm_mode", comm_mode, 0);
    endtask

    task automatic t_deglitch();
        do_reset();
        uv_raw = 1; us_ticks(19); idle(2);
        check("R2 uv after 19 ticks", reg_flags[0], 0);
        uv_raw = 0; idle(1); uv_raw = 1; us_ticks(19); idle(2);
        check("R2 glitch restarted count", reg_flags[0], 0);
        us_ticks(1); idle(2);
        check("R2 uv on 20th tick", reg_flags[0], 1);
        check("R2 force on uv", out_force, 1);
        ov_raw = 1; us_ticks(20); idle(2);
        check("R2 ov qualified", reg_flags[1], 1);
    endtask

    task automatic t_temp();
        do_reset();
        ot_raw = 1; ms_ticks(7); idle(2);
        check("R3 ot before 8th ms tick", reg_flags[2], 0);
        ms_ticks(1); idle(2);
        check("R3 ot on 8th ms tick", reg_flags[2], 1);
        check("R8 code ot", out_code, 3);
        ut_raw = 1; ot_raw = 0; ms_ticks(8); idle(2);
        check("R3 ut sampled", reg_flags[3], 1);
    endtask

    task automatic t_sticky_clear();
        do_reset();
        uv_raw = 1; us_ticks(20); idle(2);
        pulse_read();
        check("R4 clear loses while cond present", reg_flags[0], 1);
        uv_raw = 0; idle(3);
        check("R4 sticky after cond gone", reg_flags[0], 1);
        pulse_read();
        check("R5 read clears", reg_flags[0], 0);
        uv_raw = 1; us_ticks(20); uv_raw = 0; idle(2);
        pwm_report = 1; @(negedge clk); pwm_report = 0; idle(2);
        check("R5 pwm report clears", reg_flags[0], 0);
        // set coinciding with a clear: hold raw high, clear on the qualifying tick
        uv_raw = 1; us_ticks(19);
        tick_us = 1; @(negedge clk); tick_us = 0; reg_read = 1; @(negedge clk);
        reg_read = 0; idle(2);
        check("R4 set wins over clear", reg_flags[0], 1);
    endtask

    task automatic t_hold_fast();
        do_reset();
        uv_raw = 1; us_ticks(20); uv_raw = 0; idle(2);
        pulse_read();
        check("R6 flag cleared", reg_flags[0], 0);
        check("R6 force held", out_force, 1);
        check("R8 code held during hold", out_code, 1);
        ms_ticks(2);
        uv_raw = 1; us_ticks(20); uv_raw = 0; idle(2); pulse_read();
        ms_ticks(4);
        check("R6 restart still forcing", out_force, 1);
        ms_ticks(1); idle(1);
        check("R6 released after 5 ms", out_force, 0);
        check("R8 code none", out_code, 0);
    endtask

    task automatic t_hold_slow();
        do_reset();
        pwm_slow = 1;
        uv_raw = 1; us_ticks(20); uv_raw = 0; idle(2); pulse_read();
        ms_ticks(15);
        check("R7 forced at 15 ms", out_force, 1);
        ms_ticks(1); idle(1);
        check("R7 released at 16 ms", out_force, 0);
    endtask

    task automatic t_priority();
        do_reset();
        ot_raw = 1; ms_ticks(8);
        uv_raw = 1; us_ticks(20); idle(2);
        check("R8 uv outranks ot", out_code, 1);
        uv_raw = 0; idle(2); pulse_read();
        check("R8 ot after uv cleared", out_code, 3);
    endtask

    task automatic t_disable();
        do_reset();
        diag_en = 4'b1110;
        uv_raw = 1; us_ticks(20); idle(2);
        check("R9 disabled no flag", reg_flags, 0);
        check("R9 disabled no force", out_force, 0);
    endtask

    task automatic t_por();
        do_reset();
        por_active = 1; idle(2);
        check("R10 hiz in por", out_hiz, 1);
        check("R10 no force in por", out_force, 0);
        por_active = 0; idle(2);
        check("R10 uv after por", reg_flags[0], 1);
        check("R10 uv in sent path 2", sent_flags[8], 1);
        do_reset();
        diag_en = 4'b1110;
        por_active = 1; idle(2); por_active = 0; idle(2);
        check("R10 no uv when disabled", reg_flags[0], 0);
    endtask

    task automatic t_comm();
        do_reset();
        diag_en = 4'b1101; digital_mode = 1; mtrig_cfg = 2'b10;
        ov_raw = 1; us_ticks(20); idle(2);
        check("R11 trigger 2 no comm", comm_mode, 0);
        mtrig_cfg = 2'b01; idle(2);
        check("R11 trigger 1 comm", comm_mode, 1);
        check("R11 hiz in comm", out_hiz, 1);
        ov_raw = 0; mtrig_cfg = 2'b11; idle(3);
        check("R11 comm sticky", comm_mode, 1);
    endtask

    task automatic t_sent();
        do_reset();
        uv_raw = 1; us_ticks(20); uv_raw = 0; idle(2);
        sent_tx = 3'b010; @(negedge clk); sent_tx = '0; idle(2);
        check("R12 path1 cleared", sent_flags[4], 0);
        check("R12 path0 kept", sent_flags[0], 1);
        check("R12 path2 kept", sent_flags[8], 1);
        check("R12 main kept", reg_flags[0], 1);
        sent_tx = 3'b001; @(negedge clk); sent_tx = '0; idle(2);
        check("R12 path0 cleared", sent_flags[0], 0);
    endtask

    initial begin
        t_reset();
        t_deglitch();
        t_temp();
        t_sticky_clear();
        t_hold_fast();
        t_hold_slow();
        t_priority();
        t_disable();
        t_por();
        t_comm();
        t_sent();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule